// File: doc/BRIEF.md
# Double-Precision NaN and Special-Case Resolver

This block runs alongside a double-precision arithmetic unit that adds, subtracts, multiplies, divides and takes square roots. For every issued operation it inspects both 64-bit operands and decides whether the answer is already known without arithmetic. A NaN input is propagated with its sign and payload. An IEEE invalid case produces the default NaN. In all other cases the decision is handed back to the arithmetic path. A signaling NaN or an invalid case raises an invalid flag. If the invalid exception is unmasked, the block requests a trap instead of supplying a result.

The outcome appears one clock after the issue strobe, together with an output-valid pulse. When `bypass` is high, `result` replaces the arithmetic result. When it is low, the main datapath result is used. A mode input selects how two NaN inputs are merged. In one setting the first (destination) operand wins. In the other, the operand with the numerically larger 51-bit payload wins.

Top module: `fp_nan_resolver`

## Requirements
- R1: In a two-operand operation (opcode 3'b000 add, 3'b001 subtract, 3'b010 multiply, 3'b011 divide) with exactly one NaN operand, the result takes that operand's sign bit (63) and fraction bits 50..0, with exponent bits 62..52 all ones and bit 51 set.
- R2: When both operands are NaN and `max_payload` is 0, the result takes the sign and fraction bits 50..0 of `opa`, whatever the operation.
- R3: When both operands are NaN and `max_payload` is 1, the result takes the sign and bits 50..0 of the operand whose bits 50..0 are numerically larger. If the two are equal, `opa` wins.
- R4: Square root (opcode 3'b100) of a NaN `opa` returns the sign and bits 50..0 of `opa` with bit 51 set. `opb` has no effect on any square root.
- R5: Adding infinities of opposite sign, subtracting infinities of equal sign, multiplying zero by infinity in either order, 0/0, and infinity/infinity all raise `invalid` and give 64'hFFF8000000000000 when there is no NaN input.
- R6: A signaling NaN input (exponent all ones, bit 51 clear, fraction non-zero) raises `invalid`. With `inv_mask` set, the NaN chosen under R1 to R4 is delivered with bit 51 forced to 1 and `bypass` high.
- R7: Quiet NaN inputs with no signaling NaN among them raise neither `invalid` nor `trap_req`.
- R8: When `invalid` is raised and `inv_mask` is 0, `trap_req` is high and `bypass` is low.
- R9: Square root of -0 is not invalid. It yields -0 with `bypass` high. Square root of any other negative non-NaN operand, -infinity included, is invalid and yields the default NaN.
- R10: When no special case applies, or the opcode is 3'b101 to 3'b111, `bypass`, `invalid` and `trap_req` stay low.
- R11: `out_valid` is high exactly in the cycle after `in_valid` was sampled high. While `out_valid` is low, `bypass`, `invalid` and `trap_req` are low.
- R12: After reset, `out_valid`, `result`, `bypass`, `invalid` and `trap_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| op | input | 3 | Operation code |
| opa | input | 64 | First (destination) operand |
| opb | input | 64 | Second operand |
| inv_mask | input | 1 | 1 masks the invalid exception |
| max_payload | input | 1 | 1 selects the larger-payload merge of two NaNs |
| out_valid | output | 1 | Outcome valid, one cycle after issue |
| result | output | 64 | Resolved special result |
| bypass | output | 1 | Use `result` instead of the arithmetic result |
| invalid | output | 1 | Invalid-operation flag |
| trap_req | output | 1 | Unmasked invalid exception, no result written |

## Verification
The assertions take for granted that `op`, the operands and the two control bits are stable, known values in every cycle where `in_valid` is high. They also assume that reset is released away from a clock edge. The bench changes inputs only on falling edges and keeps `in_valid` high across the whole sweep, so every issued vector is defined. The sweep covers all ten representative operand classes in both operand positions, combined with every opcode, both mask settings and both merge modes. This exercises the invalid, trap and payload-selection paths in every combination.

// File: rtl/fpnr_pkg.sv
package fpnr_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'b000,
      OP_SUB  = 3'b001,
      OP_MUL  = 3'b010,
      OP_DIV  = 3'b011,
      OP_SQRT = 3'b100
   } fpnr_op_e;

   typedef struct packed {
      logic sign;
      logic is_nan;
      logic is_snan;
      logic is_inf;
      logic is_zero;
   } fpnr_class_t;

endpackage

// File: rtl/fpnr_classify.sv
module fpnr_classify
   import fpnr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = EXP_W + FRAC_W + 1
) (
   input  logic [W-1:0] val,
   output fpnr_class_t  cls
);

   logic exp_ones, exp_zero, frac_zero;

   assign exp_ones  = &val[W-2:FRAC_W];
   assign exp_zero  = ~|val[W-2:FRAC_W];
   assign frac_zero = ~|val[FRAC_W-1:0];

   always_comb begin
      cls.sign    = val[W-1];
      cls.is_nan  = exp_ones & ~frac_zero;
      cls.is_snan = exp_ones & ~frac_zero & ~val[FRAC_W-1];
      cls.is_inf  = exp_ones & frac_zero;
      cls.is_zero = exp_zero & frac_zero;
   end

endmodule

// File: rtl/fpnr_select.sv
module fpnr_select
   import fpnr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = EXP_W + FRAC_W + 1,
   localparam int PAY_W = FRAC_W - 1
) (
   input  logic [2:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  fpnr_class_t  ca,
   input  fpnr_class_t  cb,
   input  logic         max_payload,
   output logic         special,
   output logic         inv,
   output logic [W-1:0] res
);

   localparam logic [W-1:0] DEFAULT_NAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {PAY_W{1'b0}}};

   function automatic logic [W-1:0] quieten(input logic [W-1:0] x);
      return {x[W-1], {EXP_W{1'b1}}, 1'b1, x[PAY_W-1:0]};
   endfunction

   logic          b_wins_max;
   logic [W-1:0]  two_nan_pick;
   logic          bad_case;

   assign b_wins_max   = b[PAY_W-1:0] > a[PAY_W-1:0];
   assign two_nan_pick = (max_payload && b_wins_max) ? b : a;

   always_comb begin
      case (fpnr_op_e'(op))
         OP_ADD:  bad_case = ca.is_inf & cb.is_inf & (ca.sign ^ cb.sign);
         OP_SUB:  bad_case = ca.is_inf & cb.is_inf & ~(ca.sign ^ cb.sign);
         OP_MUL:  bad_case = (ca.is_zero & cb.is_inf) | (ca.is_inf & cb.is_zero);
         OP_DIV:  bad_case = (ca.is_zero & cb.is_zero) | (ca.is_inf & cb.is_inf);
         default: bad_case = 1'b0;
      endcase
   end

   always_comb begin
      special = 1'b0;
      inv     = 1'b0;
      res     = '0;
      if (fpnr_op_e'(op) == OP_SQRT) begin
         if (ca.is_nan) begin
            special = 1'b1;
            inv     = ca.is_snan;
            res     = quieten(a);
         end else if (ca.sign && ca.is_zero) begin
            special = 1'b1;
            res     = a;
         end else if (ca.sign) begin
            special = 1'b1;
            inv     = 1'b1;
            res     = DEFAULT_NAN;
         end
      end else if (op < 3'b100) begin
         if (ca.is_nan || cb.is_nan) begin
            special = 1'b1;
            inv     = ca.is_snan | cb.is_snan;
            if (ca.is_nan && cb.is_nan) res = quieten(two_nan_pick);
            else if (ca.is_nan)         res = quieten(a);
            else                        res = quieten(b);
         end else if (bad_case) begin
            special = 1'b1;
            inv     = 1'b1;
            res     = DEFAULT_NAN;
         end
      end
   end

endmodule

// File: rtl/fp_nan_resolver.sv
module fp_nan_resolver
   import fpnr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = EXP_W + FRAC_W + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [2:0]   op,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         inv_mask,
   input  logic         max_payload,
   output logic         out_valid,
   output logic [W-1:0] result,
   output logic         bypass,
   output logic         invalid,
   output logic         trap_req
);

   generate
      if (FRAC_W < 2) begin : g_bad_frac
         $error("FRAC_W must leave room for a quiet bit and a payload");
      end
      if (EXP_W < 2) begin : g_bad_exp
         $error("EXP_W must be at least 2");
      end
   endgenerate

   logic [W-1:0] opnd [2];
   fpnr_class_t  cls  [2];

   assign opnd[0] = opa;
   assign opnd[1] = opb;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_cls
         fpnr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val (opnd[i]),
            .cls (cls[i])
         );
      end
   endgenerate

   logic         sel_special, sel_inv;
   logic [W-1:0] sel_res;

   fpnr_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
      .op          (op),
      .a           (opa),
      .b           (opb),
      .ca          (cls[0]),
      .cb          (cls[1]),
      .max_payload (max_payload),
      .special     (sel_special),
      .inv         (sel_inv),
      .res         (sel_res)
   );

   logic raise_trap;
   assign raise_trap = sel_inv & ~inv_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         bypass    <= 1'b0;
         invalid   <= 1'b0;
         trap_req  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result   <= sel_res;
            bypass   <= sel_special & ~raise_trap;
            invalid  <= sel_inv;
            trap_req <= raise_trap;
         end else begin
            bypass   <= 1'b0;
            invalid  <= 1'b0;
            trap_req <= 1'b0;
         end
      end
   end

   // R11
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R11
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(bypass || invalid || trap_req));
   // R8
   trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (invalid && !bypass));
   // R8
   trap_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !inv_mask) |=> (invalid == trap_req));
   // R6
   quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && invalid) |-> (result[FRAC_W-1] && (&result[W-2:FRAC_W])));
   // R6
   masked_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && inv_mask) |=> !trap_req);

endmodule

// File: tb/fp_nan_resolver_tb.sv
module fp_nan_resolver_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op = 3'b000;
   logic [63:0] opa = '0, opb = '0;
   logic        inv_mask = 1'b0, max_payload = 1'b0;
   logic        out_valid, bypass, invalid, trap_req;
   logic [63:0] result;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   fp_nan_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opa(opa), .opb(opb), .inv_mask(inv_mask), .max_payload(max_payload),
      .out_valid(out_valid), .result(result), .bypass(bypass),
      .invalid(invalid), .trap_req(trap_req)
   );

   localparam logic [63:0] DNAN = 64'hFFF8_0000_0000_0000;

   function automatic logic [63:0] sample_val(input int k);
      case (k)
         0: return 64'h0000_0000_0000_0000;
         1: return 64'h8000_0000_0000_0000;
         2: return 64'h3FF8_0000_0000_0000;
         3: return 64'hC000_0000_0000_0000;
         4: return 64'h7FF0_0000_0000_0000;
         5: return 64'hFFF0_0000_0000_0000;
         6: return 64'h7FF8_0000_0000_0123;
         7: return 64'hFFFC_0000_0000_0456;
         8: return 64'h7FF4_0000_0000_0789;
         default: return 64'hFFF0_0000_0000_0001;
      endcase
   endfunction

   function automatic bit f_nan(input logic [63:0] x);
      return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
   endfunction
   function automatic bit f_snan(input logic [63:0] x);
      return f_nan(x) && !x[51];
   endfunction
   function automatic bit f_inf(input logic [63:0] x);
      return (x[62:52] == 11'h7FF) && (x[51:0] == 0);
   endfunction
   function automatic bit f_zero(input logic [63:0] x);
      return x[62:0] == 0;
   endfunction
   function automatic logic [63:0] f_q(input logic [63:0] x);
      return x | 64'h7FF8_0000_0000_0000;
   endfunction

   task automatic predict(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                          input bit msk, input bit mx,
                          output bit e_byp, output bit e_inv, output bit e_trp,
                          output logic [63:0] e_res, output string req);
      bit sp = 0;
      e_inv = 0; e_res = '0; req = "R10";
      if (o == 3'b100) begin
         if (f_nan(a)) begin
            sp = 1; e_inv = f_snan(a); e_res = f_q(a); req = "R4";
         end else if (a == 64'h8000_0000_0000_0000) begin
            sp = 1; e_res = a; req = "R9";
         end else if (a[63]) begin
            sp = 1; e_inv = 1; e_res = DNAN; req = "R9";
         end
      end else if (o <= 3'b011) begin
         if (f_nan(a) && f_nan(b)) begin
            sp = 1; e_inv = f_snan(a) || f_snan(b);
            if (mx && (b[50:0] > a[50:0])) e_res = f_q(b); else e_res = f_q(a);
            req = mx ? "R3" : "R2";
         end else if (f_nan(a) || f_nan(b)) begin
            sp = 1; e_inv = f_snan(a) || f_snan(b);
            e_res = f_nan(a) ? f_q(a) : f_q(b); req = "R1";
         end else begin
            bit bad;
            case (o)
               3'b000:  bad = f_inf(a) && f_inf(b) && (a[63] != b[63]);
               3'b001:  bad = f_inf(a) && f_inf(b) && (a[63] == b[63]);
               3'b010:  bad = (f_zero(a) && f_inf(b)) || (f_inf(a) && f_zero(b));
               default: bad = (f_zero(a) && f_zero(b)) || (f_inf(a) && f_inf(b));
            endcase
            if (bad) begin sp = 1; e_inv = 1; e_res = DNAN; req = "R5"; end
         end
         if (sp && (f_nan(a) || f_nan(b))) req = {req, e_inv ? "/R6" : "/R7"};
      end
      e_trp = e_inv && !msk;
      e_byp = sp && !e_trp;
      if (e_trp) req = {req, "/R8"};
   endtask

   task automatic check_out(input string req, input bit e_byp, input bit e_inv,
                            input bit e_trp, input logic [63:0] e_res);
      n_tests++;
      if (out_valid !== 1'b1 || bypass !== e_byp || invalid !== e_inv || trap_req !== e_trp
          || (e_byp && result !== e_res)) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h b=%h: vld=%b byp=%b inv=%b trp=%b res=%h, expected vld=1 byp=%b inv=%b trp=%b res=%h",
                  req, op, opa, opb, out_valid, bypass, invalid, trap_req, result,
                  e_byp, e_inv, e_trp, e_res);
      end
   endtask

   task automatic run_vec(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                          input bit msk, input bit mx);
      bit eb, ei, et;
      logic [63:0] er;
      string rq;
      op = o; opa = a; opb = b; inv_mask = msk; max_payload = mx; in_valid = 1'b1;
      predict(o, a, b, msk, mx, eb, ei, et, er, rq);
      @(negedge clk);
      check_out(rq, eb, ei, et, er);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // R12 reset state
      n_tests++;
      if (out_valid !== 0 || result !== 0 || bypass !== 0 || invalid !== 0 || trap_req !== 0) begin
         n_fail++;
         $display("FAIL R12 reset: vld=%b res=%h byp=%b inv=%b trp=%b, expected all 0",
                  out_valid, result, bypass, invalid, trap_req);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // Directed: R3 tie picks opa, R4 opb ignored, R9 sqrt of -0
      run_vec(3'b010, 64'h7FF8_0000_0000_00AA, 64'hFFF8_0000_0000_00AA, 1'b1, 1'b1);
      run_vec(3'b100, 64'hFFF8_0000_0000_0042, 64'h7FF0_0000_0000_0001, 1'b1, 1'b0);
      run_vec(3'b100, 64'h8000_0000_0000_0000, 64'hFFF0_0000_0000_0001, 1'b0, 1'b0);

      for (int ai = 0; ai < 10; ai++)
         for (int bi = 0; bi < 10; bi++)
            for (int o = 0; o < 8; o++)
               for (int m = 0; m < 4; m++)
                  run_vec(3'(o), sample_val(ai), sample_val(bi), m[0], m[1]);

      // R11 idle: no pulse and no flags without a strobe
      in_valid = 1'b0;
      @(negedge clk);
      n_tests++;
      if (out_valid !== 0 || bypass !== 0 || invalid !== 0 || trap_req !== 0) begin
         n_fail++;
         $display("FAIL R11 idle: vld=%b byp=%b inv=%b trp=%b, expected 0 0 0 0",
                  out_valid, bypass, invalid, trap_req);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule